// File: doc/BRIEF.md
# Memory-Mapped 64-bit System Tick Timer

The block is a free-standing system timer built around a 64-bit up-counter that software reads and writes over a 32-bit register bus. Each counter step is driven by one of several tick sources; a control word picks the source, sets a power-of-four prescaler, can halt counting, and selects one of two compare behaviours. In periodic mode the counter wraps to zero on the step that finds its low word equal to the compare value. In free-running mode it keeps counting and only signals the match.

Counting also needs an enable input that comes from a shared timer-enable register outside the block. Each match sets a sticky flag that drives the interrupt output. Software clears the flag by writing 1 to it. The counter is 64 bits wide, but the bus only moves 32 bits at a time, so reading the low word also copies the high word into a shadow register. A later read of the shadow then gives a high half that belongs with the low half just read.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `bus_rvalid` is 0.
- R2: The compare value (offset 0x00) reads back as written. The control word (offset 0x0C) keeps only bits 0-2, 5:3, 9 and 15, so writing all ones reads back 0x0000823F.
- R3: Control bits 0, 1 and 2 select `src_tick[0]`, `[1]` and `[2]` as the tick source. If several bits are set, the lowest-numbered one wins, and ticks on the other inputs are ignored. If none is set, the counter does not advance.
- R4: Prescale code c in control bits 5:3 advances the counter once every 4^c selected ticks, and codes 6 and 7 act as 1024. Writing the control word restarts the prescale phase, so n ticks give floor(n / divisor) advances.
- R5: Selected ticks are ignored, and the prescale phase is held, while `run_en` is 0 or control bit 9 (halt) is 1.
- R6: With control bit 15 at 0, an advance that finds the low count word equal to the compare value sets the count to 0. From a count of 0 with compare C, n advances therefore give n mod (C+1).
- R7: With control bit 15 at 1, the count adds 1 on every advance, passes the compare value and carries from the low word into the high word.
- R8: An advance whose low word equals the compare value sets the sticky flag, which is status offset 0x10 bit 0 and is also driven on `irq`. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R9: Reading the low count word (0x04) copies the live high word into the shadow (0x1C), which then holds until the next low-word read. Reading 0x08 returns the live high word.
- R10: `bus_rvalid` is high in the cycle after each `bus_rd`, with `bus_rdata` holding the addressed register. Writes to 0x04 and 0x08 load the low and high count words, and a write takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| src_tick | input | 3 | Per-source tick enables, one bit per source |
| run_en | input | 1 | Enable from the shared timer-enable register |
| irq | output | 1 | Compare-match interrupt, the sticky flag |

## Verification
The bench builds the block with its default parameters: a 32-bit data word (a 64-bit count), three tick sources and a largest prescale code of 5. Because the count words can be loaded over the bus, the bench can set the counter just below the low-to-high carry without waiting 2^32 ticks. Running every prescale code, 6 and 7 included, at up to three divisor periods keeps the 1024 divisor inside a short run. Randomly chosen small compare values let the periodic wrap repeat several times in one window.

// File: rtl/sys_tick_timer_pkg.sv
package sys_tick_timer_pkg;
  localparam int ADDR_W = 5;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFF_CMP  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_LO   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_HI   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_SHD  = 5'h1C;

  // control word layout
  localparam int CB_DIV_LO = 3;
  localparam int CODE_W    = 3;
  localparam int CB_HALT   = 9;
  localparam int CB_FREE   = 15;
  localparam logic [31:0] CTRL_MASK = 32'h0000_823F;
endpackage

// File: rtl/stt_prescale.sv
module stt_prescale #(
  parameter int NSRC     = 3,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_tick,
  input  logic [NSRC-1:0]   src_en,
  input  logic [CODE_W-1:0] code,
  input  logic              run,
  input  logic              restart,
  output logic              adv
);
  localparam int PRE_W = 2 * MAX_CODE;
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

  logic [PRE_W-1:0]  pcnt_q;
  logic [CODE_W-1:0] eff_code;
  logic [PRE_W:0]    span;
  logic [PRE_W:0]    lim;
  logic              sel_tick;
  logic              found;
  logic              step;
  logic              at_lim;

  // lowest-numbered enabled source wins
  always_comb begin
    sel_tick = 1'b0;
    found    = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_en[i] && !found) begin
        sel_tick = src_tick[i];
        found    = 1'b1;
      end
    end
  end

  assign eff_code = (code > MAX_C) ? MAX_C : code;
  assign span     = (PRE_W+1)'(1) << (2 * eff_code);
  assign lim      = span - (PRE_W+1)'(1);
  assign step     = run && sel_tick;
  assign at_lim   = {1'b0, pcnt_q} >= lim;
  assign adv      = step && at_lim;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt_q <= '0;
    end else if (step) begin
      if (at_lim) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          free_mode,
  input  logic [DW-1:0] cmp,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] cnt,
  output logic          hit
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q;

  assign hit = adv && (cnt_q[DW-1:0] == cmp);
  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[DW-1:0]  <= wdata;
      if (wr_hi) cnt_q[CW-1:DW] <= wdata;
    end else if (adv) begin
      if (hit && !free_mode) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/stt_regs.sv
module stt_regs
  import sys_tick_timer_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSRC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [2*DW-1:0]   cnt,
  input  logic              hit,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic [DW-1:0]     cmp,
  output logic [NSRC-1:0]   src_en,
  output logic [CODE_W-1:0] code,
  output logic              halt,
  output logic              free_mode,
  output logic              ctrl_wr,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              irq
);
  logic [DW-1:0] cmp_q;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] shadow_q;
  logic          flag_q;
  logic [DW-1:0] rd_mux;

  assign ctrl_wr   = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_lo     = bus_wr && (bus_addr == OFF_LO);
  assign wr_hi     = bus_wr && (bus_addr == OFF_HI);
  assign cmp       = cmp_q;
  assign src_en    = ctrl_q[NSRC-1:0];
  assign code      = ctrl_q[CB_DIV_LO +: CODE_W];
  assign halt      = ctrl_q[CB_HALT];
  assign free_mode = ctrl_q[CB_FREE];
  assign irq       = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFF_CMP) cmp_q  <= bus_wdata;
      if (ctrl_wr)             ctrl_q <= bus_wdata & DW'(CTRL_MASK);
    end
  end

  // match sets, write-one clears; a set in the same cycle wins
  always_ff @(posedge clk) begin
    if (rst)                                                     flag_q <= 1'b0;
    else if (hit)                                                flag_q <= 1'b1;
    else if (bus_wr && (bus_addr == OFF_STAT) && bus_wdata[0])   flag_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      OFF_CMP:  rd_mux = cmp_q;
      OFF_LO:   rd_mux = cnt[DW-1:0];
      OFF_HI:   rd_mux = cnt[2*DW-1:DW];
      OFF_CTRL: rd_mux = ctrl_q;
      OFF_STAT: rd_mux = {{(DW-1){1'b0}}, flag_q};
      OFF_SHD:  rd_mux = shadow_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      shadow_q   <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_rd && (bus_addr == OFF_LO)) shadow_q <= cnt[2*DW-1:DW];
    end
  end
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import sys_tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NSRC     = 3,
  parameter int MAX_CODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              run_en,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] cmp_q;
  logic [NSRC-1:0]   src_en;
  logic [CODE_W-1:0] code;
  logic              halt;
  logic              free_mode;
  logic              ctrl_wr;
  logic              wr_lo;
  logic              wr_hi;
  logic              adv;
  logic              hit;
  logic [CNT_W-1:0]  cnt_q;

  stt_regs #(.DW(DATA_W), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .cnt(cnt_q), .hit(hit), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cmp(cmp_q), .src_en(src_en), .code(code),
    .halt(halt), .free_mode(free_mode), .ctrl_wr(ctrl_wr), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .irq(irq)
  );

  stt_prescale #(.NSRC(NSRC), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_pre (
    .clk(clk), .rst(rst), .src_tick(src_tick), .src_en(src_en), .code(code),
    .run(run_en && !halt), .restart(ctrl_wr), .adv(adv)
  );

  stt_counter #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .free_mode(free_mode), .cmp(cmp_q),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata), .cnt(cnt_q), .hit(hit)
  );
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk
  import sys_tick_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              clr_bit,
  input logic [DW-1:0]     bus_rdata,
  input logic              bus_rvalid,
  input logic              run_en,
  input logic              irq,
  input logic              adv,
  input logic              hit,
  input logic              free_mode,
  input logic [2*DW-1:0]   cnt
);
  logic cnt_wr;
  assign cnt_wr = bus_wr && ((bus_addr == OFF_LO) || (bus_addr == OFF_HI));

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !cnt_wr) |=> $stable(cnt));

  assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && hit && !free_mode && !cnt_wr) |=> (cnt == '0));

  assert_free_step_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && free_mode && !cnt_wr) |=> (cnt == $past(cnt) + (2*DW)'(1)));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    hit |=> irq);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == OFF_STAT) && clr_bit && !hit) |=> !irq);

  assert_live_high_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == OFF_HI)) |=> (bus_rdata == $past(cnt[2*DW-1:DW])));
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .clr_bit(bus_wdata[0]), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .run_en(run_en), .irq(irq), .adv(adv), .hit(hit), .free_mode(free_mode),
  .cnt(cnt_q)
);

// File: tb/sys_tick_timer_bench.sv
module sys_tick_timer_bench;
  localparam logic [4:0] A_CMP = 5'h00, A_LO = 5'h04, A_HI = 5'h08;
  localparam logic [4:0] A_CTRL = 5'h0C, A_STAT = 5'h10, A_SHD = 5'h1C;
  localparam logic [31:0] FREE = 32'h8000, HALT = 32'h0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [2:0]  src_tick = '0;
  logic        run_en = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  sys_tick_timer u_sys_tick_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_tick(src_tick), .run_en(run_en), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, got %0d cycles exp fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int divisor(input int code);
    return (code > 5) ? 1024 : (1 << (2 * code));
  endfunction

  function automatic int periodic(input int n, input int c);
    return n % (c + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic ticks(input logic [2:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_tick = pat;
    end
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic set_count(input logic [31:0] hi, input logic [31:0] lo);
    wr(A_HI, hi);
    wr(A_LO, lo);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'd0);
    rd(A_CMP, v);  chk("R1 cmp", v, 0);
    rd(A_LO, v);   chk("R1 lo", v, 0);
    rd(A_HI, v);   chk("R1 hi", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_SHD, v);  chk("R1 shadow", v, 0);

    // R2: readback and control mask
    for (int k = 0; k < 4; k++) begin
      logic [31:0] c = $urandom();
      wr(A_CMP, c); rd(A_CMP, v); chk("R2 cmp", v, c);
    end
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h0000_823F);

    // R10: count words loadable
    set_count(32'hA5A5_0001, 32'h1234_5678);
    rd(A_LO, v); chk("R10 lo load", v, 32'h1234_5678);
    rd(A_HI, v); chk("R10 hi load", v, 32'hA5A5_0001);

    // R3: source selection
    run_en = 1'b1;
    wr(A_CMP, 32'hFFFF_FFFF);
    wr(A_CTRL, FREE | 32'h2);
    set_count(0, 0);
    ticks(3'b001, 10); rd(A_LO, v); chk("R3 unselected src ignored", v, 0);
    ticks(3'b010, 10); rd(A_LO, v); chk("R3 selected src", v, 10);
    wr(A_CTRL, FREE | 32'h6);
    ticks(3'b100, 5);  rd(A_LO, v); chk("R3 lowest bit wins", v, 10);
    ticks(3'b010, 5);  rd(A_LO, v); chk("R3 lowest bit counts", v, 15);
    wr(A_CTRL, FREE);
    ticks(3'b111, 8);  rd(A_LO, v); chk("R3 no source", v, 15);

    // R4: prescaler, every code including 6 and 7
    for (int code = 0; code < 8; code++) begin
      int n = $urandom_range(0, 3 * divisor(code));
      wr(A_CTRL, FREE | 32'h1 | (32'(code) << 3));
      set_count(0, 0);
      ticks(3'b001, n);
      rd(A_LO, v); chk("R4 prescale", v, 32'(n / divisor(code)));
    end

    // R5: gating by run_en and halt, with prescale phase held
    wr(A_CTRL, FREE | 32'h1 | (32'd1 << 3));
    set_count(0, 0);
    ticks(3'b001, 2);
    run_en = 1'b0;
    ticks(3'b001, 9);
    rd(A_LO, v); chk("R5 run_en low", v, 0);
    run_en = 1'b1;
    ticks(3'b001, 2);
    rd(A_LO, v); chk("R5 phase held", v, 1);
    wr(A_CTRL, FREE | HALT | 32'h1);
    ticks(3'b001, 7);
    rd(A_LO, v); chk("R5 halt", v, 1);

    // R6 and R8: periodic mode with random compare values
    for (int k = 0; k < 5; k++) begin
      int c = $urandom_range(2, 11);
      int n = $urandom_range(0, 40);
      wr(A_CTRL, 32'h1);
      wr(A_CMP, 32'(c));
      set_count(0, 0);
      wr(A_STAT, 32'h1);
      ticks(3'b001, n);
      rd(A_LO, v); chk("R6 periodic wrap", v, 32'(periodic(n, c)));
      rd(A_HI, v); chk("R6 high stays 0", v, 0);
      chk("R8 irq on match", {31'b0, irq}, (n > c) ? 32'd1 : 32'd0);
    end

    // R8: sticky flag, write-0 ignored, write-1 clears
    wr(A_CTRL, 32'h1); wr(A_CMP, 32'd3); set_count(0, 0); wr(A_STAT, 32'h1);
    ticks(3'b001, 4);
    rd(A_STAT, v); chk("R8 flag set", v, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R8 write 0 ignored", v, 1);
    chk("R8 irq held", {31'b0, irq}, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R8 cleared", v, 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);

    // R7: free mode passes compare and carries into high word
    wr(A_CTRL, FREE | 32'h1); wr(A_CMP, 32'd5); set_count(0, 0); wr(A_STAT, 32'h1);
    ticks(3'b001, 10);
    rd(A_LO, v); chk("R7 passes compare", v, 10);
    chk("R8 flag in free mode", {31'b0, irq}, 1);
    set_count(32'd7, 32'hFFFF_FFFE);
    ticks(3'b001, 3);
    rd(A_LO, v); chk("R7 carry low", v, 1);
    rd(A_HI, v); chk("R7 carry high", v, 8);

    // R9: shadow capture and hold
    run_en = 1'b0;
    set_count(32'h0000_1234, 32'h0000_0042);
    rd(A_LO, v); chk("R9 low read", v, 32'h42);
    rd(A_SHD, v); chk("R9 shadow captured", v, 32'h1234);
    wr(A_HI, 32'h0000_5555);
    rd(A_HI, v); chk("R9 live high", v, 32'h5555);
    rd(A_SHD, v); chk("R9 shadow held", v, 32'h1234);
    rd(A_LO, v);
    rd(A_SHD, v); chk("R9 shadow recaptured", v, 32'h5555);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule